// File: doc/BRIEF.md
# Serial Transmit Queue with Buffered Shifter

This block is the transmit half of a clocked synchronous serial channel. Software writes bytes into a small queue: a 4-entry FIFO in front of one transmit holding buffer, so five bytes can wait before anything is sent. While transmit is enabled and the shifter is idle, the buffered byte moves into an 8-bit shift register. The shift register drives a data line and a serial clock made by a fixed divider. As soon as the buffer empties and the FIFO holds data, the oldest FIFO byte refills the buffer.

A 2-bit fill level sets when a single-cycle transmit interrupt fires as the FIFO drains. With auto-disable set, the transmit enable clears itself when the queue and the shifter have both run dry. The serial clock then stays parked. With auto-disable clear, the channel stays enabled and idles until more bytes arrive. When the FIFO is switched off, the holding buffer is the only storage.

Top module: `ser_tx_chain`

## Requirements
- R1: With the FIFO enabled, five writes are accepted while transmit is off. A sixth write is dropped and sets `overrun_o`, which stays at 1 until a FIFO clear.
- R2: Each byte goes out LSB first, in write order. `sclk_o` idles high. Each bit period lasts 2*HALF_DIV system clocks. `sd_o` changes only together with a falling edge of `sclk_o`, so receivers sample on the rising edge.
- R3: While `txe_o` is 0, `sclk_o` does not toggle, whatever is written.
- R4: `buf_empty_o` goes to 0 in the cycle after a byte enters the transmit buffer. It returns to 1 when the buffer is unloaded into the shifter and no FIFO data remains to refill it.
- R5: With the FIFO enabled, `tx_irq_o` is a one-cycle pulse in the cycle after the FIFO count falls from `fill_lvl_i`+1 to `fill_lvl_i`. At level 0 this is when the last queued byte moves into the buffer. At level 2, from a full queue, it fires while the second byte is in flight.
- R6: With `auto_dis_i` at 1, `txe_o` clears itself in the same cycle as the shifter finishes its last byte, once the buffer and FIFO are empty. After that `sclk_o` stays high.
- R7: With `auto_dis_i` at 0, `txe_o` stays 1 after the queue drains. `sclk_o` stays idle, and a later write is sent without software enabling transmit again.
- R8: A pulse on `fifo_clr_i` empties the FIFO and clears `overrun_o`, but it leaves a byte already in the transmit buffer, and that byte is still sent.
- R9: With the FIFO disabled, the buffer holds the only queued byte, and a write to a full buffer sets `overrun_o`. `tx_irq_o` pulses once for each buffer-to-shifter transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | DW | Byte to queue |
| fifo_en_i | input | 1 | FIFO enable |
| fifo_clr_i | input | 1 | FIFO clear strobe |
| txe_wr_i | input | 1 | Strobe that loads the transmit enable |
| txe_val_i | input | 1 | Value loaded into the transmit enable |
| fill_lvl_i | input | LW | FIFO count at which the interrupt fires |
| auto_dis_i | input | 1 | Self-clear transmit enable when drained |
| txe_o | output | 1 | Current transmit enable |
| buf_empty_o | output | 1 | Transmit buffer empty flag |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| overrun_o | output | 1 | Sticky dropped-write flag |
| sd_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |

## Verification
A corrupted FIFO pointer or count shows up on the serial line as a byte out of order, repeated or missing. It appears within one byte time, 16*HALF_DIV cycles, of the bad entry reaching the shifter. A wrong count also moves or suppresses the interrupt pulse, which the bench sees relative to the number of bytes already received. A wrong buffer-valid bit shows on `buf_empty_o` one cycle later and stalls or duplicates shifting. A shifter counter fault changes the number of `sclk_o` rising edges or leaves `txe_o` set after the queue drains.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int unsigned cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = ser_tx_pkg::cnt_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && !clr_i && wr_ptr_q == AW'(g)) mem_q[g] <= data_i;
    end
  end

  // R1: the controller never pushes into a full queue unless a pop frees a slot
  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o && !pop_i));
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int unsigned DW       = 8,
  parameter int unsigned HALF_DIV = 2,
  localparam int unsigned DVW     = $clog2(HALF_DIV) + 1,
  localparam int unsigned BW      = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          sclk_o,
  output logic          sd_o
);
  logic [DW-1:0]  sh_q;
  logic [DVW-1:0] div_q;
  logic [BW-1:0]  bit_q;
  logic           busy_q, sclk_q, sd_q;
  logic           half_end;

  assign half_end = busy_q && (div_q == DVW'(HALF_DIV - 1));
  assign done_o   = half_end && sclk_q && (bit_q == BW'(DW - 1));
  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign sd_o     = sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      sd_q   <= 1'b1;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      sd_q   <= data_i[0];
      sh_q   <= data_i >> 1;
      div_q  <= '0;
      bit_q  <= '0;
    end else if (half_end) begin
      div_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else if (bit_q == BW'(DW - 1)) begin
        busy_q <= 1'b0;
      end else begin
        sclk_q <= 1'b0;
        sd_q   <= sh_q[0];
        sh_q   <= sh_q >> 1;
        bit_q  <= bit_q + BW'(1);
      end
    end else if (busy_q) begin
      div_q <= div_q + DVW'(1);
    end
  end

  p_sd_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(sclk_o));
  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);
  p_no_reload_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/ser_tx_chain.sv
module ser_tx_chain #(
  parameter int unsigned DW       = ser_tx_pkg::BYTE_W,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned HALF_DIV = 2,
  localparam int unsigned CW      = ser_tx_pkg::cnt_w(DEPTH),
  localparam int unsigned LW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          fifo_en_i,
  input  logic          fifo_clr_i,
  input  logic          txe_wr_i,
  input  logic          txe_val_i,
  input  logic [LW-1:0] fill_lvl_i,
  input  logic          auto_dis_i,
  output logic          txe_o,
  output logic          buf_empty_o,
  output logic          tx_irq_o,
  output logic          overrun_o,
  output logic          sd_o,
  output logic          sclk_o
);
  logic [DW-1:0] buf_q, fifo_rd;
  logic [CW-1:0] fifo_cnt;
  logic          buf_vld_q, txe_q, irq_q, ovr_q;
  logic          fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic          sh_busy, sh_done, sh_load, direct_wr, drop_wr, lvl_hit;

  assign sh_load   = txe_q && buf_vld_q && !sh_busy;
  assign fifo_pop  = fifo_en_i && !fifo_empty && (!buf_vld_q || sh_load);
  assign fifo_push = fifo_en_i && wr_en_i && (!fifo_full || fifo_pop);
  assign direct_wr = !fifo_en_i && wr_en_i && (!buf_vld_q || sh_load);
  assign drop_wr   = wr_en_i && !fifo_push && !direct_wr;
  assign lvl_hit   = fifo_pop && !fifo_push && (fifo_cnt == CW'(fill_lvl_i) + CW'(1));

  ser_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .push_i  (fifo_push),
    .data_i  (wr_data_i),
    .pop_i   (fifo_pop),
    .data_o  (fifo_rd),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  ser_tx_shifter #(.DW(DW), .HALF_DIV(HALF_DIV)) shift_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sh_load),
    .data_i (buf_q),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .sclk_o (sclk_o),
    .sd_o   (sd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q     <= '0;
      buf_vld_q <= 1'b0;
      txe_q     <= 1'b0;
      irq_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (fifo_pop) begin
        buf_q     <= fifo_rd;
        buf_vld_q <= 1'b1;
      end else if (direct_wr) begin
        buf_q     <= wr_data_i;
        buf_vld_q <= 1'b1;
      end else if (sh_load) begin
        buf_vld_q <= 1'b0;
      end

      if (txe_wr_i)
        txe_q <= txe_val_i;
      else if (auto_dis_i && sh_done && !buf_vld_q && fifo_empty)
        txe_q <= 1'b0;

      irq_q <= fifo_en_i ? lvl_hit : sh_load;

      if (fifo_clr_i)   ovr_q <= 1'b0;
      else if (drop_wr) ovr_q <= 1'b1;
    end
  end

  assign txe_o       = txe_q;
  assign buf_empty_o = !buf_vld_q;
  assign tx_irq_o    = irq_q;
  assign overrun_o   = ovr_q;

  p_buf_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop |=> !buf_empty_o);
  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);
  p_ovr_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !fifo_clr_i) |=> overrun_o);
  p_no_shift_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!txe_o && !sh_busy) |=> sclk_o);
  p_auto_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(txe_o) && !$past(txe_wr_i)) |-> (sclk_o && buf_empty_o));
endmodule

// File: tb/ser_tx_chain_tb_top.sv
module ser_tx_chain_tb_top;
  localparam int HALF = 2;
  localparam int BYTE_CYC = 16 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fifo_en = 1'b1;
  logic       fifo_clr = 1'b0;
  logic       txe_wr = 1'b0;
  logic       txe_val = 1'b0;
  logic [1:0] fill_lvl = '0;
  logic       auto_dis = 1'b1;
  logic       txe, buf_empty, tx_irq, overrun, sd, sclk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // monitor state
  int   rx_cnt = 0;
  int   rise_cnt = 0;
  int   irq_cnt = 0;
  int   irq_rx = -1;
  int   bit_cnt = 0;
  logic [7:0] acc = '0;
  logic [7:0] rx_mem [64];
  logic prev_sclk = 1'b1;

  always #2 clk = ~clk;

  ser_tx_chain #(.DW(8), .DEPTH(4), .HALF_DIV(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fifo_en_i(fifo_en), .fifo_clr_i(fifo_clr), .txe_wr_i(txe_wr),
    .txe_val_i(txe_val), .fill_lvl_i(fill_lvl), .auto_dis_i(auto_dis),
    .txe_o(txe), .buf_empty_o(buf_empty), .tx_irq_o(tx_irq),
    .overrun_o(overrun), .sd_o(sd), .sclk_o(sclk)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_irq) begin
        irq_cnt = irq_cnt + 1;
        irq_rx  = rx_cnt;
      end
      if (sclk && !prev_sclk) begin
        rise_cnt = rise_cnt + 1;
        acc = {sd, acc[7:1]};
        bit_cnt = bit_cnt + 1;
        if (bit_cnt == 8) begin
          rx_mem[rx_cnt % 64] = acc;
          rx_cnt  = rx_cnt + 1;
          bit_cnt = 0;
        end
      end
    end
    prev_sclk = sclk;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = base + 8'(i * 17);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_txe(input logic v);
    @(negedge clk);
    txe_wr = 1'b1;
    txe_val = v;
    @(negedge clk);
    txe_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic wait_txe_low(input int limit);
    for (int i = 0; i < limit && txe; i++) @(negedge clk);
  endtask

  task automatic wait_rx(input int target, input int limit);
    for (int i = 0; i < limit && rx_cnt < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R4 reset buf_empty", buf_empty, 1);
    chk("R2 reset sclk idle high", sclk, 1);
    chk("R5 reset irq", tx_irq, 0);
    chk("R1 reset overrun", overrun, 0);
    chk("R6 reset txe", txe, 0);
  endtask

  // R1/R2/R3/R5/R6: five-byte burst, level 0, auto-disable
  task automatic t_burst_lvl0();
    int rb, ib, rsb;
    fifo_en = 1'b1; auto_dis = 1'b1; fill_lvl = 2'd0;
    pulse_clr();
    rb = rx_cnt; ib = irq_cnt; rsb = rise_cnt;
    write_burst(5, 8'h31);
    chk("R4 buf loaded", buf_empty, 0);
    chk("R1 no overrun at five", overrun, 0);
    write_burst(1, 8'hEE);
    chk("R1 sixth write overrun", overrun, 1);
    idle(40);
    chk("R3 no clock while disabled", rise_cnt - rsb, 0);
    set_txe(1'b1);
    wait_txe_low(20 * BYTE_CYC);
    chk("R6 txe self-cleared", txe, 0);
    chk("R2 byte count", rx_cnt - rb, 5);
    for (int i = 0; i < 5; i++)
      chk("R2 byte order LSB first", rx_mem[(rb + i) % 64], 8'h31 + 8'(i * 17));
    chk("R5 one irq at level 0", irq_cnt - ib, 1);
    chk("R5 irq after three bytes", irq_rx - rb, 3);
    chk("R4 buf empty after drain", buf_empty, 1);
    chk("R1 overrun sticky", overrun, 1);
    rsb = rise_cnt;
    idle(3 * BYTE_CYC);
    chk("R6 clock stopped", rise_cnt - rsb, 0);
    chk("R6 sclk parked high", sclk, 1);
  endtask

  // R8: clear empties FIFO, keeps buffer, clears overrun
  task automatic t_clear();
    int rb;
    pulse_clr();
    chk("R8 overrun cleared", overrun, 0);
    rb = rx_cnt;
    write_burst(3, 8'h52);
    pulse_clr();
    chk("R8 buffer kept", buf_empty, 0);
    set_txe(1'b1);
    wait_txe_low(20 * BYTE_CYC);
    idle(2 * BYTE_CYC);
    chk("R8 only buffered byte sent", rx_cnt - rb, 1);
    chk("R8 buffered byte value", rx_mem[rb % 64], 8'h52);
    chk("R8 txe off after single byte", txe, 0);
  endtask

  // R5: threshold at level 2
  task automatic t_lvl2();
    int rb, ib;
    fill_lvl = 2'd2; auto_dis = 1'b1;
    pulse_clr();
    rb = rx_cnt; ib = irq_cnt;
    write_burst(5, 8'h0F);
    set_txe(1'b1);
    wait_txe_low(20 * BYTE_CYC);
    chk("R5 one irq at level 2", irq_cnt - ib, 1);
    chk("R5 irq after one byte", irq_rx - rb, 1);
    chk("R2 level 2 byte count", rx_cnt - rb, 5);
    chk("R2 last byte", rx_mem[(rb + 4) % 64], 8'h0F + 8'(4 * 17));
    fill_lvl = 2'd0;
  endtask

  // R7: no auto-disable keeps transmit enabled
  task automatic t_no_auto();
    int rb, rsb;
    auto_dis = 1'b0;
    pulse_clr();
    rb = rx_cnt;
    set_txe(1'b1);
    write_burst(2, 8'hA5);
    wait_rx(rb + 2, 10 * BYTE_CYC);
    idle(BYTE_CYC);
    chk("R7 txe stays set", txe, 1);
    chk("R7 buf empty idle", buf_empty, 1);
    rsb = rise_cnt;
    idle(2 * BYTE_CYC);
    chk("R7 clock idle with no data", rise_cnt - rsb, 0);
    write_burst(1, 8'h3C);
    wait_rx(rb + 3, 10 * BYTE_CYC);
    chk("R7 late byte sent", rx_mem[(rb + 2) % 64], 8'h3C);
    chk("R7 still enabled", txe, 1);
    set_txe(1'b0);
    auto_dis = 1'b1;
  endtask

  // R9: FIFO disabled, buffer only
  task automatic t_no_fifo();
    int rb, ib;
    fifo_en = 1'b0;
    pulse_clr();
    rb = rx_cnt; ib = irq_cnt;
    write_burst(1, 8'hC3);
    chk("R9 buffer holds byte", buf_empty, 0);
    chk("R9 no overrun yet", overrun, 0);
    write_burst(1, 8'h77);
    chk("R9 second write overrun", overrun, 1);
    set_txe(1'b1);
    wait_txe_low(10 * BYTE_CYC);
    chk("R9 one byte sent", rx_cnt - rb, 1);
    chk("R9 byte value", rx_mem[rb % 64], 8'hC3);
    chk("R9 irq per transfer", irq_cnt - ib, 1);
    fifo_en = 1'b1;
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_burst_lvl0();
    t_clear();
    t_lvl2();
    t_no_auto();
    t_no_fifo();
    idle(5);
    summary();
  end
endmodule